// File: doc/BRIEF.md
# Framed Packet Network Interface

This block is a simple network card for a chip-level register bus. Software sees four 32-bit registers at the bottom of the block's address space: a receive interrupt register, a transmit interrupt register, a control register and a read-only status register. Above them sit a receive packet buffer and a transmit packet buffer. Each buffer is 4 KB, and the pair is mapped at byte offset 32768. Packets use an 8-byte big-endian header made of a framing word, a source address, a total length that counts the header, and a destination address.

To send a packet, software builds it in the transmit buffer and then sets the send bit. The card replaces the framing word and the source address with its own values. It then streams exactly as many bytes as the length field gives and raises the transmit interrupt. On the receive side the card takes in a framed byte stream and keeps it in the receive buffer. It signals arrival only when the header is well formed and the packet is meant for this card. While a receive interrupt is pending, every new frame is dropped, so software can copy the buffer without it being overwritten.

Top module: `framed_nic`

## Requirements
- R1: After reset, the receive interrupt register (offset 0), the transmit interrupt register (offset 4) and the control register (offset 8) read 0, and `irq` is low. A bus read returns its data on `bus_rdata` in the cycle after `bus_rd` is sampled.
- R2: The status register (offset 12) reads `{16'h0000, station_addr}`. Bus writes to it have no effect.
- R3: A transmit streams exactly L bytes, where L is the 16-bit length field held in bits 31:16 of transmit buffer word 1 (byte offsets 4 and 5). The first four bytes are always 0xA4, 0xB3, `station_addr[15:8]` and `station_addr[7:0]`, whatever the buffer holds there. Every later byte k comes from transmit buffer offset k, and words are packed big-endian, so byte 4n+0 sits in bits 31:24. The bytes appear on consecutive cycles, and `tx_last` marks the final byte.
- R4: When a transmit ends, bit 0 of the transmit interrupt register is set and control bit 1 (send) clears itself. Control bit 0 (promiscuous) keeps its value.
- R5: A transmit whose length field is below 8 or above 4096 produces no bytes but still sets the transmit interrupt and clears the send bit.
- R6: A received frame addressed to `station_addr` or to 0xFFFF, with a valid header, sets bit 0 of the receive interrupt register. Its bytes can then be read at offset 32768 onward, packed big-endian as for transmit.
- R7: With control bit 0 clear, a frame whose destination (header bytes 6 and 7) is neither the station address nor 0xFFFF is dropped. With control bit 0 set, it is accepted.
- R8: A frame is dropped without raising the receive interrupt in three cases: its first two bytes are not 0xA4 0xB3, its length field (header bytes 4 and 5) is below 8 or above 4096, or it is shorter than 8 bytes.
- R9: A frame that begins while the receive interrupt is set is dropped completely. The receive buffer contents stay as they were and the interrupt stays set.
- R10: Writing a value with bit 0 clear to an interrupt register clears that register. `irq` is high exactly when either interrupt register is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the register or buffer access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| station_addr | input | 16 | Hardware address of this card |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Marks the final byte of an incoming frame |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Marks the final outgoing byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that software never sets the send bit while a transmit is already running. They also assume that `rx_last` is only meaningful together with `rx_valid`, and that a frame's bytes arrive back to back. The bench respects both limits: it writes the control register only after the previous transmit has raised its interrupt, and it presents each frame as an unbroken run of bytes with idle cycles between frames. Under these conditions the properties check three things: the transmit stream is contiguous and begins with the framing byte, the interrupt and send-bit changes follow the engine's completion, and no receive write happens while an arrival is pending.

// File: rtl/fnic_pkg.sv
package fnic_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_LEN, TX_CHK, TX_SEND} tx_state_t;
  localparam logic [15:0] FRAME_WORD = 16'hA4B3;
  localparam logic [15:0] BCAST_ADDR = 16'hFFFF;
  localparam int          HDR_BYTES  = 8;
endpackage

// File: rtl/fnic_txbuf.sv
module fnic_txbuf #(
  parameter int WORDS = 1024,
  parameter int WA    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [WA-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  input  logic [WA-1:0] rd_addr,
  output logic [31:0]   rd_q
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_wdata;
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/fnic_rxbuf.sv
module fnic_rxbuf #(
  parameter int WORDS = 1024,
  parameter int WA    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [WA+1:0] wbyte,
  input  logic [7:0]    wdata,
  input  logic [WA-1:0] host_addr,
  output logic [31:0]   host_q
);
  // one byte-wide memory per lane; byte 0 of a word lives in lane 3
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (we && wbyte[1:0] == 2'(3 - g)) mem[wbyte[WA+1:2]] <= wdata;
      q <= mem[host_addr];
    end
    assign host_q[8*g +: 8] = q;
  end
endmodule

// File: rtl/fnic_tx.sv
module fnic_tx
  import fnic_pkg::*;
#(
  parameter int BUF_BYTES = 4096,
  parameter int WA        = $clog2(BUF_BYTES / 4),
  parameter int IDX_W     = WA + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [15:0]   station,
  output logic [WA-1:0] rd_addr,
  input  logic [31:0]   rd_q,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          done
);
  localparam logic [15:0] MIN_LEN = 16'(HDR_BYTES);
  localparam logic [15:0] MAX_LEN = 16'(BUF_BYTES);

  tx_state_t        state;
  logic [IDX_W-1:0] byte_idx, len, nxt_idx;
  logic [15:0]      len16;
  logic             len_ok, is_last;
  logic [7:0]       sel;

  assign len16   = rd_q[31:16];
  assign len_ok  = (len16 >= MIN_LEN) && (len16 <= MAX_LEN);
  assign nxt_idx = byte_idx + 1'b1;
  assign is_last = (nxt_idx == len);
  assign done    = (state == TX_CHK && !len_ok) || (state == TX_SEND && is_last);

  // read address runs one byte ahead so rd_q always holds the current word
  always_comb begin
    case (state)
      TX_LEN:  rd_addr = WA'(1);
      TX_SEND: rd_addr = nxt_idx[WA+1:2];
      default: rd_addr = '0;
    endcase
  end

  always_comb begin
    if (byte_idx < IDX_W'(4)) begin
      case (byte_idx[1:0])
        2'd0:    sel = FRAME_WORD[15:8];
        2'd1:    sel = FRAME_WORD[7:0];
        2'd2:    sel = station[15:8];
        default: sel = station[7:0];
      endcase
    end else begin
      case (byte_idx[1:0])
        2'd0:    sel = rd_q[31:24];
        2'd1:    sel = rd_q[23:16];
        2'd2:    sel = rd_q[15:8];
        default: sel = rd_q[7:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TX_IDLE;
      byte_idx  <= '0;
      len       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      case (state)
        TX_IDLE: if (go) state <= TX_LEN;
        TX_LEN:  state <= TX_CHK;
        TX_CHK: begin
          byte_idx <= '0;
          len      <= len16[IDX_W-1:0];
          state    <= len_ok ? TX_SEND : TX_IDLE;
        end
        TX_SEND: begin
          out_valid <= 1'b1;
          out_data  <= sel;
          out_last  <= is_last;
          byte_idx  <= nxt_idx;
          if (is_last) state <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fnic_rx.sv
module fnic_rx
  import fnic_pkg::*;
#(
  parameter int BUF_BYTES = 4096,
  parameter int BA        = $clog2(BUF_BYTES),
  parameter int IDX_W     = BA + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic [15:0]   station,
  input  logic          promisc,
  input  logic          pending,
  output logic          we,
  output logic [BA-1:0] wbyte,
  output logic [7:0]    wdata,
  output logic          accept
);
  localparam logic [15:0] MIN_LEN = 16'(HDR_BYTES);
  localparam logic [15:0] MAX_LEN = 16'(BUF_BYTES);

  logic             active, drop;
  logic [IDX_W-1:0] idx;
  logic [15:0]      fw_q, len_q, dst_q, dst_eff;
  logic             drop_now, hdr_done, addr_ok, hdr_ok;

  // the pending flag is sampled only on the first byte of a frame
  assign drop_now = active ? drop : pending;
  assign we       = in_valid && !drop_now && (idx < IDX_W'(BUF_BYTES));
  assign wbyte    = idx[BA-1:0];
  assign wdata    = in_data;

  assign hdr_done = idx >= IDX_W'(7);
  assign dst_eff  = (idx == IDX_W'(7)) ? {dst_q[15:8], in_data} : dst_q;
  assign addr_ok  = promisc || dst_eff == station || dst_eff == BCAST_ADDR;
  assign hdr_ok   = fw_q == FRAME_WORD && len_q >= MIN_LEN && len_q <= MAX_LEN;
  assign accept   = in_valid && in_last && !drop_now && hdr_done && hdr_ok && addr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      drop   <= 1'b0;
      idx    <= '0;
      fw_q   <= '0;
      len_q  <= '0;
      dst_q  <= '0;
    end else if (in_valid) begin
      case (idx)
        IDX_W'(0): fw_q[15:8]  <= in_data;
        IDX_W'(1): fw_q[7:0]   <= in_data;
        IDX_W'(4): len_q[15:8] <= in_data;
        IDX_W'(5): len_q[7:0]  <= in_data;
        IDX_W'(6): dst_q[15:8] <= in_data;
        IDX_W'(7): dst_q[7:0]  <= in_data;
        default: ;
      endcase
      if (in_last) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        active <= 1'b1;
        drop   <= drop_now;
        if (idx < IDX_W'(BUF_BYTES)) idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/framed_nic.sv
module framed_nic #(
  parameter int BUF_BYTES = 4096,
  parameter int ADDR_W    = 16,
  parameter int BUF_BASE  = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       station_addr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              irq
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int WA    = $clog2(WORDS);
  localparam int BA    = $clog2(BUF_BYTES);
  localparam int IDX_W = BA + 1;
  localparam logic [ADDR_W-1:0] RX_LO  = ADDR_W'(BUF_BASE);
  localparam logic [ADDR_W-1:0] TX_LO  = ADDR_W'(BUF_BASE + BUF_BYTES);
  localparam logic [ADDR_W-1:0] TX_END = ADDR_W'(BUF_BASE + 2 * BUF_BYTES);
  localparam logic [ADDR_W-1:0] REG_END = ADDR_W'(16);

  logic          in_rx, in_tx, is_reg;
  logic          wr_rxi, wr_txi, wr_ctl;
  logic          rx_irq_q, tx_irq_q, promisc_q, send_q;
  logic          rsel_q;
  logic [31:0]   reg_q, rxbuf_q, txbuf_q;
  logic [WA-1:0] tx_rd_addr;
  logic          tx_done, rx_we, rx_accept;
  logic [BA-1:0] rx_wbyte;
  logic [7:0]    rx_wdata;

  assign in_rx  = bus_addr >= RX_LO && bus_addr < TX_LO;
  assign in_tx  = bus_addr >= TX_LO && bus_addr < TX_END;
  assign is_reg = bus_addr < REG_END;
  assign wr_rxi = bus_wr && is_reg && bus_addr[3:2] == 2'd0;
  assign wr_txi = bus_wr && is_reg && bus_addr[3:2] == 2'd1;
  assign wr_ctl = bus_wr && is_reg && bus_addr[3:2] == 2'd2;

  fnic_txbuf #(.WORDS(WORDS), .WA(WA)) u_txbuf (
    .clk(clk), .host_we(bus_wr && in_tx), .host_addr(bus_addr[WA+1:2]),
    .host_wdata(bus_wdata), .rd_addr(tx_rd_addr), .rd_q(txbuf_q)
  );

  fnic_rxbuf #(.WORDS(WORDS), .WA(WA)) u_rxbuf (
    .clk(clk), .we(rx_we), .wbyte(rx_wbyte), .wdata(rx_wdata),
    .host_addr(bus_addr[WA+1:2]), .host_q(rxbuf_q)
  );

  fnic_tx #(.BUF_BYTES(BUF_BYTES), .WA(WA), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst(rst), .go(send_q), .station(station_addr),
    .rd_addr(tx_rd_addr), .rd_q(txbuf_q), .out_valid(tx_valid),
    .out_data(tx_data), .out_last(tx_last), .done(tx_done)
  );

  fnic_rx #(.BUF_BYTES(BUF_BYTES), .BA(BA), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_data(rx_data),
    .in_last(rx_last), .station(station_addr), .promisc(promisc_q),
    .pending(rx_irq_q), .we(rx_we), .wbyte(rx_wbyte), .wdata(rx_wdata),
    .accept(rx_accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq_q  <= 1'b0;
      tx_irq_q  <= 1'b0;
      promisc_q <= 1'b0;
      send_q    <= 1'b0;
    end else begin
      if (rx_accept)   rx_irq_q <= 1'b1;
      else if (wr_rxi) rx_irq_q <= rx_irq_q & bus_wdata[0];
      if (tx_done)     tx_irq_q <= 1'b1;
      else if (wr_txi) tx_irq_q <= tx_irq_q & bus_wdata[0];
      if (wr_ctl)      promisc_q <= bus_wdata[0];
      if (tx_done)     send_q <= 1'b0;
      else if (wr_ctl) send_q <= send_q | bus_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= 1'b0;
      reg_q  <= '0;
    end else if (bus_rd) begin
      rsel_q <= in_rx;
      if (!is_reg) reg_q <= '0;
      else begin
        case (bus_addr[3:2])
          2'd0:    reg_q <= {31'd0, rx_irq_q};
          2'd1:    reg_q <= {31'd0, tx_irq_q};
          2'd2:    reg_q <= {30'd0, send_q, promisc_q};
          default: reg_q <= {16'd0, station_addr};
        endcase
      end
    end
  end

  assign bus_rdata = rsel_q ? rxbuf_q : reg_q;
  assign irq       = rx_irq_q | tx_irq_q;
endmodule

// File: rtl/fnic_chk.sv
module fnic_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       tx_done,
  input logic       tx_irq_q,
  input logic       send_q,
  input logic       rx_irq_q,
  input logic       rx_we
);
  // R3
  tx_first_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !$past(tx_valid)) |-> tx_data == 8'hA4);
  // R3
  tx_burst_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_last) |=> tx_valid);
  // R3
  tx_last_chk: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);
  // R4
  tx_done_irq_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> tx_irq_q);
  // R4
  send_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(send_q) |-> $past(tx_done));
  // R4
  tx_irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_irq_q) |-> $past(tx_done));
  // R9
  rx_pending_block_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq_q |-> !rx_we);
endmodule

bind framed_nic fnic_chk u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_last(tx_last), .tx_done(tx_done), .tx_irq_q(tx_irq_q),
  .send_q(send_q), .rx_irq_q(rx_irq_q), .rx_we(rx_we)
);

// File: tb/framed_nic_test.sv
module framed_nic_test;
  localparam logic [15:0] STN = 16'h5A17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_last, irq;
  logic [7:0]  tx_data;

  int nchk = 0, nerr = 0;
  bit finished = 0;
  logic [8:0] exp_q [$];
  logic [7:0] pk [0:15];

  always #10 clk = ~clk;

  framed_nic uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .station_addr(STN),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic hdr(input logic [15:0] fw, input logic [15:0] src,
                     input logic [15:0] len, input logic [15:0] dst);
    pk[0] = fw[15:8];  pk[1] = fw[7:0];  pk[2] = src[15:8]; pk[3] = src[7:0];
    pk[4] = len[15:8]; pk[5] = len[7:0]; pk[6] = dst[15:8]; pk[7] = dst[7:0];
  endtask

  // load nw words of pk into the transmit buffer
  task automatic load_tx(input int nw);
    for (int w = 0; w < nw; w++)
      bwrite(16'h9000 + 16'(4 * w), {pk[4*w], pk[4*w+1], pk[4*w+2], pk[4*w+3]});
  endtask

  // scoreboard driver: expected stream for n bytes of pk
  task automatic expect_tx(input int n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      case (k)
        0: b = 8'hA4;
        1: b = 8'hB3;
        2: b = STN[15:8];
        3: b = STN[7:0];
        default: b = pk[k];
      endcase
      exp_q.push_back({k == n - 1, b});
    end
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irq) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic rx_frame(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pk[k]; rx_last = (k == n - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      if (exp_q.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL R3/R5 unexpected byte actual=%h expected=none", tx_data);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R3 tx byte/last", {23'd0, tx_last, tx_data}, {23'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R2 reset state
    chk("R1 irq after reset", {31'd0, irq}, 0);
    bread(16'd0, d);  chk("R1 rx irq reg", d, 0);
    bread(16'd4, d);  chk("R1 tx irq reg", d, 0);
    bread(16'd8, d);  chk("R1 control reg", d, 0);
    bread(16'd12, d); chk("R2 status", d, {16'd0, STN});
    bwrite(16'd12, 32'hFFFF_0000);
    bread(16'd12, d); chk("R2 status write ignored", d, {16'd0, STN});

    // R3 / R4 transmit of 13 bytes, garbage in framing/source
    hdr(16'hDEAD, 16'hBEEF, 16'd13, 16'h0042);
    for (int k = 8; k < 16; k++) pk[k] = 8'(8'h10 + k - 8);
    load_tx(4);
    expect_tx(13);
    bwrite(16'd8, 32'h3);
    wait_irq();
    chk("R3 all bytes sent", exp_q.size(), 0);
    chk("R10 irq after tx", {31'd0, irq}, 1);
    bread(16'd4, d); chk("R4 tx irq set", d, 1);
    bread(16'd8, d); chk("R4 send cleared promisc kept", d, 1);
    bwrite(16'd4, 32'h1);
    bread(16'd4, d); chk("R10 write 1 keeps", d, 1);
    bwrite(16'd4, 32'h0);
    bread(16'd4, d); chk("R10 tx irq cleared", d, 0);
    chk("R10 irq low", {31'd0, irq}, 0);
    bwrite(16'd8, 32'h0);

    // R3 minimum length 8
    hdr(16'h0000, 16'h0000, 16'd8, 16'hFFFF);
    load_tx(2);
    expect_tx(8);
    bwrite(16'd8, 32'h2);
    wait_irq();
    chk("R3 len 8 all sent", exp_q.size(), 0);
    bread(16'd4, d); chk("R4 tx irq len 8", d, 1);
    bwrite(16'd4, 32'h0);

    // R5 length too short, then too long
    hdr(16'hA4B3, STN, 16'd6, 16'h0042);
    load_tx(2);
    bwrite(16'd8, 32'h2);
    wait_irq();
    bread(16'd4, d); chk("R5 len 6 completes", d, 1);
    bread(16'd8, d); chk("R5 len 6 send cleared", d, 0);
    bwrite(16'd4, 32'h0);
    hdr(16'hA4B3, STN, 16'd4097, 16'h0042);
    load_tx(2);
    bwrite(16'd8, 32'h2);
    wait_irq();
    bread(16'd4, d); chk("R5 len 4097 completes", d, 1);
    bwrite(16'd4, 32'h0);

    // R6 receive addressed to this station
    hdr(16'hA4B3, 16'h0001, 16'd10, STN);
    pk[8] = 8'hC1; pk[9] = 8'hC2;
    rx_frame(10);
    chk("R6 irq on receive", {31'd0, irq}, 1);
    bread(16'd0, d);      chk("R6 rx irq reg", d, 1);
    bread(16'h8000, d);   chk("R6 rx word0", d, 32'hA4B3_0001);
    bread(16'h8004, d);   chk("R6 rx word1", d, {16'd10, STN});
    bread(16'h8008, d);   chk("R6 rx word2", {16'd0, d[31:16]}, 32'hC1C2);

    // R9 drop while pending
    hdr(16'hA4B3, 16'h0002, 16'd10, STN);
    pk[8] = 8'hD1; pk[9] = 8'hD2;
    rx_frame(10);
    bread(16'h8008, d);   chk("R9 buffer kept", {16'd0, d[31:16]}, 32'hC1C2);
    bread(16'h8000, d);   chk("R9 header kept", d, 32'hA4B3_0001);
    bread(16'd0, d);      chk("R9 irq still set", d, 1);
    bwrite(16'd0, 32'h0);
    bread(16'd0, d);      chk("R10 rx irq cleared", d, 0);

    // R7 other destination, not promiscuous
    hdr(16'hA4B3, 16'h0003, 16'd10, 16'h1111);
    rx_frame(10);
    bread(16'd0, d); chk("R7 foreign dropped", d, 0);

    // R6 broadcast
    hdr(16'hA4B3, 16'h0004, 16'd8, 16'hFFFF);
    rx_frame(8);
    bread(16'd0, d); chk("R6 broadcast accepted", d, 1);
    bwrite(16'd0, 32'h0);

    // R7 promiscuous
    bwrite(16'd8, 32'h1);
    hdr(16'hA4B3, 16'h0005, 16'd10, 16'h1111);
    pk[8] = 8'hE1; pk[9] = 8'hE2;
    rx_frame(10);
    bread(16'd0, d);    chk("R7 promisc accepted", d, 1);
    bread(16'h8008, d); chk("R7 promisc data", {16'd0, d[31:16]}, 32'hE1E2);
    bwrite(16'd0, 32'h0);
    bwrite(16'd8, 32'h0);

    // R8 malformed frames
    hdr(16'hA4B4, 16'h0006, 16'd10, STN);
    rx_frame(10);
    bread(16'd0, d); chk("R8 bad framing dropped", d, 0);
    hdr(16'hA4B3, 16'h0006, 16'd7, STN);
    rx_frame(10);
    bread(16'd0, d); chk("R8 length 7 dropped", d, 0);
    hdr(16'hA4B3, 16'h0006, 16'd5000, STN);
    rx_frame(10);
    bread(16'd0, d); chk("R8 length 5000 dropped", d, 0);
    hdr(16'hA4B3, 16'h0006, 16'd8, STN);
    rx_frame(6);
    bread(16'd0, d); chk("R8 short frame dropped", d, 0);
    chk("R10 irq idle at end", {31'd0, irq}, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule